// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Store

This block behaves as the slave side of a three-wire serial EEPROM organised as 16-bit words. A host drives a select line, a serial clock and a serial data input. The block returns read data on a single serial output. Every frame opens with a two-bit start pattern and a two-bit opcode. An address field follows. For reads and writes a 16-bit data field comes last. The command set covers single-word read, write and erase, array-wide write and erase, and a write-enable latch that software sets and clears. Nothing reaches the array unless that latch is set. Writes and erases commit when select is released.

A write does not replace a stored word. It ANDs the received data into it. An erase sets bits back to one. The word count is a parameter: 16, 64, 128 or 256. The three serial pins are treated as slow signals that are synchronous to the block clock, and the block finds their edges by sampling. A backdoor port lets a test environment preload and inspect words directly, without going through the serial protocol.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the serial output is 1, the write-enable latch is clear, and every word reads 0xFFFF through the backdoor.
- R2: Serial data is taken only on a rising serial-clock edge while select is high. Clock edges with select low have no effect. A rising edge of select restarts frame reception from the first start bit.
- R3: The first start bit is 0 and the second is 1. A 1 in the first position counts as both start bits. While the second start bit is awaited, extra 0 bits are ignored.
- R4: The opcode follows the start bits, MSB first. Opcode 10 is read. On the edge that delivers the last address bit of a read, the output drops to a dummy 0. Each of the next 16 rising edges then presents one bit of the addressed word, MSB first.
- R5: Opcode 00 carries a subcommand in the two most significant address bits. Subcommand 11 sets the write-enable latch and 00 clears it. Both take effect as soon as the last address bit arrives. With the latch clear, no write or erase changes the array.
- R6: Opcode 01 is write. On the falling edge of select the stored word becomes the old word AND the 16 received data bits. This happens only if all 16 data bits were received; otherwise the word is unchanged.
- R7: Opcode 11 is erase. On the falling edge of select the addressed word becomes 0xFFFF.
- R8: Under opcode 00, subcommand 01 ANDs a complete 16-bit data field into every word, and subcommand 10 sets every word to 0xFFFF. Both commit on the falling edge of select.
- R9: The address field is 6 bits for 16 or 64 words and 8 bits for 128 or 256 words. The received address is reduced modulo the word count, so each in-range address selects its own word.
- R10: The serial output returns to 1 on the falling edge of select.
- R11: Rising clock edges after the 16th data bit of a frame are ignored.
- R12: A backdoor write strobe stores the backdoor data at the backdoor address, and the backdoor read data always shows the word at the backdoor address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host, idles high |
| bd_addr_i | input | $clog2(WORDS) | Backdoor word address |
| bd_wdata_i | input | 16 | Backdoor write data |
| bd_we_i | input | 1 | Backdoor write strobe |
| bd_rdata_o | output | 16 | Backdoor read data |

## Verification
The hardest conditions to reach from the ports depend on frame length and latch state together. One is a write frame that ends after only some of its data bits. Another is a frame padded with clocks after the 16th data bit. A third is a store attempted while the latch is clear. The bench builds each frame bit by bit, so it controls exactly how many data bits and trailing clocks are sent before select drops. It then reads the target word through the backdoor to see whether the commit happened. The AND-accumulate behaviour is reached by preloading known patterns through the backdoor and writing overlapping masks before reading back serially.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  typedef enum logic [1:0] {
    SUB_WDIS = 2'b00,
    SUB_WALL = 2'b01,
    SUB_EALL = 2'b10,
    SUB_WEN  = 2'b11
  } mw_sub_e;

  typedef enum logic [2:0] {
    CM_NONE      = 3'd0,
    CM_ERASE_ONE = 3'd1,
    CM_ERASE_ALL = 3'd2,
    CM_AND_ONE   = 3'd3,
    CM_AND_ALL   = 3'd4
  } mw_commit_e;

  function automatic int addr_bits(input int words);
    return (words <= 64) ? 6 : 8;
  endfunction

endpackage

// File: rtl/mw_rst_sync.sv
module mw_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/mw_edge.sv
module mw_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sclk_i,
  output logic sel_rise_o,
  output logic sel_fall_o,
  output logic sclk_rise_o
);
  logic sel_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_i;
      sclk_q <= sclk_i;
    end
  end

  assign sel_rise_o  = sel_i & ~sel_q;
  assign sel_fall_o  = ~sel_i & sel_q;
  assign sclk_rise_o = sel_i & sclk_i & ~sclk_q;
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW    = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_rise_i,
  input  logic                       sel_fall_i,
  input  logic                       sclk_rise_i,
  input  logic                       sdi_i,
  input  logic [DW-1:0]              rd_word_i,
  output logic [$clog2(WORDS)-1:0]   rd_idx_o,
  output mw_commit_e                 cm_o,
  output logic [$clog2(WORDS)-1:0]   cm_idx_o,
  output logic [DW-1:0]              cm_data_o,
  output logic                       sdo_o
);
  localparam int ABITS      = addr_bits(WORDS);
  localparam int IDXW       = $clog2(WORDS);
  localparam int T_ADDR_END = 4 + ABITS;
  localparam int T_END      = T_ADDR_END + DW;
  localparam int TW         = $clog2(T_END + 1);

  logic [TW-1:0]    tick_q, tick_d;
  mw_op_e           op_q, op_d;
  mw_sub_e          sub_q, sub_d;
  logic [ABITS-1:0] addr_q, addr_d, full_addr;
  logic [DW-1:0]    data_q, data_d;
  logic             dout_q, dout_d;
  logic             wen_q, wen_d;
  logic             upd_en;

  assign full_addr = {addr_q[ABITS-2:0], sdi_i};
  assign upd_en    = sel_rise_i | sel_fall_i | sclk_rise_i;

  always_comb begin
    tick_d = tick_q;
    op_d   = op_q;
    sub_d  = sub_q;
    addr_d = addr_q;
    data_d = data_q;
    dout_d = dout_q;
    wen_d  = wen_q;
    cm_o   = CM_NONE;
    if (sel_rise_i) begin
      tick_d = '0;
      op_d   = OP_EXT;
      sub_d  = SUB_WDIS;
      addr_d = '0;
    end else if (sel_fall_i) begin
      dout_d = 1'b1;
      if (wen_q) begin
        if (op_q == OP_EXT && sub_q == SUB_EALL)       cm_o = CM_ERASE_ALL;
        else if (op_q == OP_ERASE)                     cm_o = CM_ERASE_ONE;
        else if (tick_q == TW'(T_END)) begin
          if (op_q == OP_WRITE)                        cm_o = CM_AND_ONE;
          else if (op_q == OP_EXT && sub_q == SUB_WALL) cm_o = CM_AND_ALL;
        end
      end
    end else if (sclk_rise_i) begin
      if (tick_q == TW'(0)) begin
        tick_d = sdi_i ? TW'(2) : TW'(1);
      end else if (tick_q == TW'(1)) begin
        if (sdi_i) tick_d = TW'(2);
      end else if (tick_q < TW'(4)) begin
        tick_d = tick_q + TW'(1);
        op_d   = mw_op_e'({op_q[0], sdi_i});
      end else if (tick_q < TW'(T_ADDR_END)) begin
        tick_d = tick_q + TW'(1);
        addr_d = full_addr;
        if (tick_q == TW'(T_ADDR_END - 1)) begin
          addr_d = ABITS'(full_addr[IDXW-1:0]);
          if (op_q == OP_READ) dout_d = 1'b0;
          if (op_q == OP_EXT) begin
            sub_d = mw_sub_e'(full_addr[ABITS-1 -: 2]);
            if (full_addr[ABITS-1 -: 2] == SUB_WDIS) wen_d = 1'b0;
            if (full_addr[ABITS-1 -: 2] == SUB_WEN)  wen_d = 1'b1;
          end else begin
            data_d = rd_word_i;
          end
        end
      end else if (tick_q < TW'(T_END)) begin
        tick_d = tick_q + TW'(1);
        if (op_q == OP_READ) dout_d = data_q[DW-1];
        data_d = {data_q[DW-2:0], sdi_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      op_q   <= OP_EXT;
      sub_q  <= SUB_WDIS;
      addr_q <= '0;
      data_q <= '0;
      dout_q <= 1'b1;
      wen_q  <= 1'b0;
    end else if (upd_en) begin
      tick_q <= tick_d;
      op_q   <= op_d;
      sub_q  <= sub_d;
      addr_q <= addr_d;
      data_q <= data_d;
      dout_q <= dout_d;
      wen_q  <= wen_d;
    end
  end

  assign rd_idx_o  = full_addr[IDXW-1:0];
  assign cm_idx_o  = addr_q[IDXW-1:0];
  assign cm_data_o = data_q;
  assign sdo_o     = dout_q;

  // R11
  tick_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q <= TW'(T_END));

  // R10
  sdo_idle_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_fall_i |=> sdo_o);

  // R4
  sdo_low_only_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dout_q) |-> (op_q == OP_READ));

  // R5
  wen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise_i |=> $stable(wen_q));

  // R5
  no_commit_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |-> (cm_o == CM_NONE));
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW    = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  mw_commit_e                 cm_i,
  input  logic [$clog2(WORDS)-1:0]   idx_i,
  input  logic [DW-1:0]              data_i,
  input  logic [$clog2(WORDS)-1:0]   rd_idx_i,
  output logic [DW-1:0]              rd_word_o,
  input  logic [$clog2(WORDS)-1:0]   bd_addr_i,
  input  logic [DW-1:0]              bd_wdata_i,
  input  logic                       bd_we_i,
  output logic [DW-1:0]              bd_rdata_o
);
  localparam int IDXW = $clog2(WORDS);

  logic [WORDS-1:0][DW-1:0] words;
  logic                     any_en;

  assign any_en = (cm_i != CM_NONE) | bd_we_i;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] q, d;
    logic          hit, bd_hit;

    assign hit    = (idx_i == IDXW'(g));
    assign bd_hit = bd_we_i && (bd_addr_i == IDXW'(g));

    always_comb begin
      d = q;
      unique case (cm_i)
        CM_ERASE_ALL: d = '1;
        CM_AND_ALL:   d = q & data_i;
        CM_ERASE_ONE: if (hit) d = '1;
        CM_AND_ONE:   if (hit) d = q & data_i;
        default:      if (bd_hit) d = bd_wdata_i;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '1;
      else if (any_en) q <= d;
    end

    assign words[g] = q;
  end

  assign rd_word_o  = words[rd_idx_i];
  assign bd_rdata_o = words[bd_addr_i];

  // R7
  erase_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_i == CM_ERASE_ONE) |=> (words[$past(idx_i)] == '1));

  // R6
  and_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_i == CM_AND_ONE) |=> (words[$past(idx_i)] == ($past(words[idx_i]) & $past(data_i))));

  // R8
  erase_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_i == CM_ERASE_ALL) |=> (words[0] == '1 && words[WORDS-1] == '1));

  // R12
  backdoor_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bd_we_i && cm_i == CM_NONE) |=> (words[$past(bd_addr_i)] == $past(bd_wdata_i)));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sel_i,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  input  logic [$clog2(WORDS)-1:0] bd_addr_i,
  input  logic [15:0]              bd_wdata_i,
  input  logic                     bd_we_i,
  output logic [15:0]              bd_rdata_o
);
  localparam int DW   = 16;
  localparam int IDXW = $clog2(WORDS);

  if (!(WORDS == 16 || WORDS == 64 || WORDS == 128 || WORDS == 256)) begin : g_bad_words
    $error("mw_eeprom: WORDS must be 16, 64, 128 or 256");
  end

  logic            rst_sync_n;
  logic            sel_rise, sel_fall, sclk_rise;
  logic [IDXW-1:0] rd_idx, cm_idx;
  logic [DW-1:0]   rd_word, cm_data;
  mw_commit_e      cm;

  mw_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  mw_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .sel_i      (sel_i),
    .sclk_i     (sclk_i),
    .sel_rise_o (sel_rise),
    .sel_fall_o (sel_fall),
    .sclk_rise_o(sclk_rise)
  );

  mw_seq #(.WORDS(WORDS), .DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .sel_rise_i (sel_rise),
    .sel_fall_i (sel_fall),
    .sclk_rise_i(sclk_rise),
    .sdi_i      (sdi_i),
    .rd_word_i  (rd_word),
    .rd_idx_o   (rd_idx),
    .cm_o       (cm),
    .cm_idx_o   (cm_idx),
    .cm_data_o  (cm_data),
    .sdo_o      (sdo_o)
  );

  mw_array #(.WORDS(WORDS), .DW(DW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .cm_i      (cm),
    .idx_i     (cm_idx),
    .data_i    (cm_data),
    .rd_idx_i  (rd_idx),
    .rd_word_o (rd_word),
    .bd_addr_i (bd_addr_i),
    .bd_wdata_i(bd_wdata_i),
    .bd_we_i   (bd_we_i),
    .bd_rdata_o(bd_rdata_o)
  );
endmodule

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
  localparam int WORDS = 64;

  typedef struct packed {
    logic [1:0]  act;
    logic [5:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 6'h05, 16'hA5A5, 16'hA5A5},
    '{2'd1, 6'h05, 16'h0FF0, 16'h05A0},
    '{2'd2, 6'h05, 16'h0000, 16'hFFFF},
    '{2'd1, 6'h3F, 16'h1234, 16'h1234},
    '{2'd1, 6'h3F, 16'hFF00, 16'h1200},
    '{2'd0, 6'h00, 16'h8001, 16'h8001},
    '{2'd2, 6'h3F, 16'h0000, 16'hFFFF},
    '{2'd0, 6'h3F, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n, sel, sclk, sdi, bd_we;
  logic        sdo;
  logic [5:0]  bd_addr;
  logic [15:0] bd_wdata, bd_rdata;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  mw_eeprom #(.WORDS(WORDS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .bd_addr_i(bd_addr), .bd_wdata_i(bd_wdata), .bd_we_i(bd_we),
    .bd_rdata_o(bd_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o);
    @(negedge clk); sclk = 1'b0; sdi = b;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); o = sdo;
  endtask

  task automatic sel_start();
    @(negedge clk); sclk = 1'b0; sel = 1'b1;
    @(negedge clk);
  endtask

  task automatic sel_end();
    @(negedge clk); sclk = 1'b0; sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] addr, output logic last_o);
    logic o;
    bit_io(1'b0, o);
    bit_io(1'b1, o);
    bit_io(op[1], o);
    bit_io(op[0], o);
    for (int i = 5; i >= 0; i--) bit_io(addr[i], o);
    last_o = o;
  endtask

  task automatic read_tail(output logic [15:0] w);
    logic o;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      bit_io(1'b0, o);
      w = {w[14:0], o};
    end
  endtask

  task automatic ser_read(input logic [5:0] addr, output logic [15:0] w);
    logic d;
    sel_start();
    send_cmd(2'b10, addr, d);
    check("R4 dummy bit", {15'd0, d}, 16'd0);
    read_tail(w);
    sel_end();
    check("R10 idle high", {15'd0, sdo}, 16'd1);
  endtask

  task automatic ser_write(input logic [1:0] op, input logic [5:0] addr,
                           input logic [15:0] data, input int nd, input int nx);
    logic o;
    sel_start();
    send_cmd(op, addr, o);
    for (int i = 0; i < nd; i++) bit_io(data[15-i], o);
    for (int i = 0; i < nx; i++) bit_io(1'b0, o);
    sel_end();
  endtask

  task automatic ser_short(input logic [1:0] op, input logic [5:0] addr);
    logic o;
    sel_start();
    send_cmd(op, addr, o);
    sel_end();
  endtask

  task automatic bd_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bd_addr = a; bd_wdata = d; bd_we = 1'b1;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic bd_read(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bd_addr = a;
    @(negedge clk); d = bd_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic        o;
    rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
    bd_we = 1'b0; bd_addr = '0; bd_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 sdo", {15'd0, sdo}, 16'd1);
    bd_read(6'h00, w); check("R1 word0", w, 16'hFFFF);
    bd_read(6'h3F, w); check("R1 word63", w, 16'hFFFF);

    // R12: backdoor round trip
    bd_write(6'h07, 16'h1357);
    bd_read(6'h07, w); check("R12 backdoor", w, 16'h1357);

    // R5: latch clear after reset, write must not commit
    ser_write(2'b01, 6'h10, 16'h0000, 16, 0);
    bd_read(6'h10, w); check("R5 locked write", w, 16'hFFFF);

    // R5: enable (subcommand 11), then the same write commits
    ser_short(2'b00, 6'b110000);
    ser_write(2'b01, 6'h10, 16'h0000, 16, 0);
    bd_read(6'h10, w); check("R5 enabled write", w, 16'h0000);

    // vector table: preload / AND-write / erase, each read back serially
    foreach (VECS[k]) begin
      case (VECS[k].act)
        2'd0:    bd_write(VECS[k].addr, VECS[k].wdata);
        2'd1:    ser_write(2'b01, VECS[k].addr, VECS[k].wdata, 16, 0);
        default: ser_short(2'b11, VECS[k].addr);
      endcase
      ser_read(VECS[k].addr, w);
      check(VECS[k].act == 2'd1 ? "R6 and-write" :
            VECS[k].act == 2'd2 ? "R7 erase" : "R4 read", w, VECS[k].exp);
    end

    // R9: top address 63 did not alias word 0
    bd_read(6'h00, w); check("R9 no alias", w, 16'h8001);

    // R3: leading 1 stands for both start bits
    bd_write(6'h05, 16'hC3C3);
    sel_start();
    bit_io(1'b1, o); bit_io(1'b1, o); bit_io(1'b0, o);
    for (int i = 5; i >= 0; i--) bit_io(6'h05 >> i, o);
    check("R3 leading one dummy", {15'd0, o}, 16'd0);
    read_tail(w);
    sel_end();
    check("R3 leading one", w, 16'hC3C3);

    // R3: extra zeros before the second start bit
    sel_start();
    bit_io(1'b0, o); bit_io(1'b0, o); bit_io(1'b0, o); bit_io(1'b1, o);
    bit_io(1'b1, o); bit_io(1'b0, o);
    for (int i = 5; i >= 0; i--) bit_io(6'h05 >> i, o);
    read_tail(w);
    sel_end();
    check("R3 extra zeros", w, 16'hC3C3);

    // R6: only 8 data bits -> no commit
    ser_write(2'b01, 6'h05, 16'h0000, 8, 0);
    bd_read(6'h05, w); check("R6 short write", w, 16'hC3C3);

    // R11: trailing clocks after 16 data bits ignored
    ser_write(2'b01, 6'h20, 16'h00FF, 16, 3);
    bd_read(6'h20, w); check("R11 trailing clocks", w, 16'h00FF);

    // R2: clocks with select low are ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sclk = 1'b1; sdi = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    ser_read(6'h20, w); check("R2 idle clocks", w, 16'h00FF);

    // R2: select rise restarts a frame after an aborted one
    sel_start();
    bit_io(1'b0, o); bit_io(1'b1, o); bit_io(1'b1, o);
    sel_end();
    ser_read(6'h20, w); check("R2 restart", w, 16'h00FF);

    // R8: write-all ANDs into every word, erase-all restores
    ser_write(2'b00, 6'b010000, 16'hF0F0, 16, 0);
    bd_read(6'h00, w); check("R8 write-all word0", w, 16'h8000);
    bd_read(6'h20, w); check("R8 write-all word32", w, 16'h00F0);
    ser_short(2'b00, 6'b100000);
    bd_read(6'h00, w); check("R8 erase-all word0", w, 16'hFFFF);
    bd_read(6'h3F, w); check("R8 erase-all word63", w, 16'hFFFF);

    // R5: disable (subcommand 00), erase must not commit
    ser_write(2'b01, 6'h11, 16'h0000, 16, 0);
    ser_short(2'b00, 6'b000000);
    ser_short(2'b11, 6'h11);
    bd_read(6'h11, w); check("R5 disabled erase", w, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule